// File: doc/BRIEF.md
# Interrupt Entry and Return Sequencer

This unit sits next to a small CPU core and takes over the core's stack and status word whenever an external interrupt is serviced or a handler returns. All request lines are merged into one pending condition. The unit starts only at an instruction boundary, and only if the enable flag in the status word is set. It then runs a fixed multicycle sequence over a single-port memory: it saves the program counter and the status word on a descending stack, turns interrupts off, pulses an acknowledge and steers the program counter to a vector address.

A return command, given at an instruction boundary, undoes the entry. It pops the status word and then the program counter from the stack. Because the restored status word carries the enable flag that was in force before entry, interrupts come back on without any separate step. The core is expected to stall while `busy` is high. It loads its program counter whenever `pc_we` is asserted.

Top module: `irq_seq`

## Requirements
- R1: The request inputs are combined by OR, so any single line being high is enough to start an entry.
- R2: An entry starts only on a clock edge where the unit is idle, `instr_end` is 1, some request line is 1 and status bit IE (bit `IE_BIT`, default 0) is 1. A request held while IE is 0, or held without a boundary, is not served. The same request is taken at the first boundary after IE becomes 1.
- R3: Entry keeps `busy` high for 7 cycles with this order of actions:
  - cycle 1: SP decrement.
  - cycle 2: memory write of the saved PC at the new SP.
  - cycle 3: SP decrement.
  - cycle 4: memory write of the status word at the new SP.
  - cycle 5: IE clear.
  - cycle 6: acknowledge.
  - cycle 7: PC load.
  - `mem_we` and `mem_re` are never high together.
- R4: SP moves by exactly one per step. Entry lowers it by 2 and return raises it by 2. Every memory access uses `mem_addr` equal to the current SP.
- R5: The status word pushed on entry is the value held before the IE clear. After entry, IE reads 0 and all other status bits are unchanged.
- R6: `irq_ack` is a one-cycle pulse. `vec_addr` is sampled in the acknowledge cycle and driven on `pc_wdata` with `pc_we` in the next cycle.
- R7: A return (`iret_req` and `instr_end` while idle) keeps `busy` high for 4 cycles:
  - cycle 1: read at SP, loaded into the status word.
  - cycle 2: SP increment.
  - cycle 3: read at SP, driven on `pc_wdata` with `pc_we`.
  - cycle 4: SP increment.
  - The restored status word turns IE back on if it was on before entry.
- R8: When a return and a takeable interrupt meet at the same boundary, the return is performed.
- R9: While busy, `psr_we`, `instr_end` and `iret_req` have no effect. While idle, `psr_we` loads `psr_wdata` into the status word. An entry started in that same cycle uses the old IE value and pushes the newly written word.
- R10: Reset clears the whole status word (so IE = 0), sets SP to `STACK_TOP`, returns to idle and drives every strobe low.
- R11: If the handler sets IE again, a nested entry stacks a second frame below the first. Two returns restore both frames in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| irq_req | input | NUM_IRQ | Level interrupt requests |
| instr_end | input | 1 | Current instruction has completed |
| iret_req | input | 1 | Return-from-interrupt command, valid with `instr_end` |
| pc_cur | input | DW | Core's current program counter |
| vec_addr | input | DW | Handler entry address |
| psr_we | input | 1 | Software write to the status word (idle only) |
| psr_wdata | input | DW | Data for the status word write |
| psr_q | output | DW | Status word |
| sp_q | output | AW | Stack pointer |
| busy | output | 1 | Sequence in progress, core must stall |
| irq_ack | output | 1 | Acknowledge pulse |
| pc_we | output | 1 | Load strobe for the core's PC |
| pc_wdata | output | DW | Value to load into the PC |
| mem_we | output | 1 | Memory write strobe |
| mem_re | output | 1 | Memory read strobe |
| mem_addr | output | AW | Memory address |
| mem_wdata | output | DW | Memory write data |
| mem_rdata | input | DW | Memory read data, valid in the same cycle as `mem_re` |

## Verification
The properties assume that the memory returns read data combinationally in the cycle `mem_re` is high. They also assume that a return is issued only when a frame is actually on the stack, so the words popped are the ones pushed. The stimulus holds each request line until its handler has been entered and drops it afterwards. It issues a return only after a matching entry, nested ones included. It drives `instr_end`, `iret_req` and `psr_we` during busy windows only to show that they are ignored.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_E_DEC1,
    ST_E_PUSH_PC,
    ST_E_DEC2,
    ST_E_PUSH_SR,
    ST_E_CLR_IE,
    ST_E_ACK,
    ST_E_VEC,
    ST_R_POP_SR,
    ST_R_INC1,
    ST_R_POP_PC,
    ST_R_INC2
  } seq_state_e;
endpackage

// File: rtl/irq_seq_rst_sync.sv
module irq_seq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) sync_q <= '0;
    else          sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_o = sync_q[STAGES-1];
endmodule

// File: rtl/irq_seq_fsm.sv
module irq_seq_fsm
  import irq_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_irq,
  input  logic       start_ret,
  output seq_state_e state_q
);
  seq_state_e state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: begin
        if (start_ret)      state_d = ST_R_POP_SR;
        else if (start_irq) state_d = ST_E_DEC1;
      end
      ST_E_DEC1:    state_d = ST_E_PUSH_PC;
      ST_E_PUSH_PC: state_d = ST_E_DEC2;
      ST_E_DEC2:    state_d = ST_E_PUSH_SR;
      ST_E_PUSH_SR: state_d = ST_E_CLR_IE;
      ST_E_CLR_IE:  state_d = ST_E_ACK;
      ST_E_ACK:     state_d = ST_E_VEC;
      ST_E_VEC:     state_d = ST_IDLE;
      ST_R_POP_SR:  state_d = ST_R_INC1;
      ST_R_INC1:    state_d = ST_R_POP_PC;
      ST_R_POP_PC:  state_d = ST_R_INC2;
      ST_R_INC2:    state_d = ST_IDLE;
      default:      state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end
endmodule

// File: rtl/irq_seq_regs.sv
module irq_seq_regs #(
  parameter int          AW        = 8,
  parameter int          DW        = 16,
  parameter int          IE_BIT    = 0,
  parameter int unsigned STACK_TOP = 240
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sp_dec,
  input  logic          sp_inc,
  input  logic          sr_sw_ld,
  input  logic [DW-1:0] sr_sw_d,
  input  logic          sr_pop_ld,
  input  logic [DW-1:0] sr_pop_d,
  input  logic          ie_clr,
  input  logic          pcs_ld,
  input  logic [DW-1:0] pcs_d,
  input  logic          vec_ld,
  input  logic [DW-1:0] vec_d,
  output logic [AW-1:0] sp_q,
  output logic [DW-1:0] sr_q,
  output logic [DW-1:0] pcs_q,
  output logic [DW-1:0] vec_q
);
  localparam logic [AW-1:0] SP_RST  = AW'(STACK_TOP);
  localparam logic [DW-1:0] IE_MASK = DW'(1) << IE_BIT;

  logic [AW-1:0] sp_d;
  logic          sp_en;
  logic [DW-1:0] sr_d;
  logic          sr_en;

  always_comb begin
    sp_en = sp_dec | sp_inc;
    sp_d  = sp_q;
    if (sp_dec)      sp_d = sp_q - 1'b1;
    else if (sp_inc) sp_d = sp_q + 1'b1;
  end

  always_comb begin
    sr_en = sr_pop_ld | ie_clr | sr_sw_ld;
    sr_d  = sr_q;
    if (sr_pop_ld)     sr_d = sr_pop_d;
    else if (ie_clr)   sr_d = sr_q & ~IE_MASK;
    else if (sr_sw_ld) sr_d = sr_sw_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sp_q <= SP_RST;
    else if (sp_en) sp_q <= sp_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sr_q <= '0;
    else if (sr_en) sr_q <= sr_d;
  end

  always_ff @(posedge clk) begin
    if (pcs_ld) pcs_q <= pcs_d;
  end

  always_ff @(posedge clk) begin
    if (vec_ld) vec_q <= vec_d;
  end
endmodule

// File: rtl/irq_seq.sv
module irq_seq
  import irq_seq_pkg::*;
#(
  parameter int          NUM_IRQ   = 4,
  parameter int          AW        = 8,
  parameter int          DW        = 16,
  parameter int          IE_BIT    = 0,
  parameter int unsigned STACK_TOP = 240
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_IRQ-1:0] irq_req,
  input  logic               instr_end,
  input  logic               iret_req,
  input  logic [DW-1:0]      pc_cur,
  input  logic [DW-1:0]      vec_addr,
  input  logic               psr_we,
  input  logic [DW-1:0]      psr_wdata,
  output logic [DW-1:0]      psr_q,
  output logic [AW-1:0]      sp_q,
  output logic               busy,
  output logic               irq_ack,
  output logic               pc_we,
  output logic [DW-1:0]      pc_wdata,
  output logic               mem_we,
  output logic               mem_re,
  output logic [AW-1:0]      mem_addr,
  output logic [DW-1:0]      mem_wdata,
  input  logic [DW-1:0]      mem_rdata
);
  logic       rst_n_s;
  seq_state_e state_q;
  logic       idle, pending, start_irq, start_ret;
  logic [DW-1:0] pcs_q, vec_q;

  irq_seq_rst_sync #(.STAGES(2)) u_rst (
    .clk     (clk),
    .rst_n_i (rst_n),
    .rst_n_o (rst_n_s)
  );

  assign idle      = (state_q == ST_IDLE);
  assign pending   = |irq_req;
  assign start_ret = idle & instr_end & iret_req;
  assign start_irq = idle & instr_end & pending & psr_q[IE_BIT] & ~iret_req;

  irq_seq_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .start_irq (start_irq),
    .start_ret (start_ret),
    .state_q   (state_q)
  );

  irq_seq_regs #(
    .AW(AW), .DW(DW), .IE_BIT(IE_BIT), .STACK_TOP(STACK_TOP)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .sp_dec    ((state_q == ST_E_DEC1) | (state_q == ST_E_DEC2)),
    .sp_inc    ((state_q == ST_R_INC1) | (state_q == ST_R_INC2)),
    .sr_sw_ld  (idle & psr_we),
    .sr_sw_d   (psr_wdata),
    .sr_pop_ld (state_q == ST_R_POP_SR),
    .sr_pop_d  (mem_rdata),
    .ie_clr    (state_q == ST_E_CLR_IE),
    .pcs_ld    (start_irq),
    .pcs_d     (pc_cur),
    .vec_ld    (state_q == ST_E_ACK),
    .vec_d     (vec_addr),
    .sp_q      (sp_q),
    .sr_q      (psr_q),
    .pcs_q     (pcs_q),
    .vec_q     (vec_q)
  );

  always_comb begin
    busy      = ~idle;
    mem_we    = (state_q == ST_E_PUSH_PC) | (state_q == ST_E_PUSH_SR);
    mem_re    = (state_q == ST_R_POP_SR) | (state_q == ST_R_POP_PC);
    mem_addr  = sp_q;
    mem_wdata = (state_q == ST_E_PUSH_PC) ? pcs_q : psr_q;
    irq_ack   = (state_q == ST_E_ACK);
    pc_we     = (state_q == ST_E_VEC) | (state_q == ST_R_POP_PC);
    pc_wdata  = (state_q == ST_E_VEC) ? vec_q : mem_rdata;
  end
endmodule

// File: rtl/irq_seq_chk.sv
module irq_seq_chk #(
  parameter int NUM_IRQ = 4,
  parameter int AW      = 8,
  parameter int DW      = 16,
  parameter int IE_BIT  = 0
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NUM_IRQ-1:0] irq_req,
  input logic               instr_end,
  input logic               iret_req,
  input logic [DW-1:0]      psr_q,
  input logic [AW-1:0]      sp_q,
  input logic               busy,
  input logic               irq_ack,
  input logic               pc_we,
  input logic               mem_we,
  input logic               mem_re
);
  // R2: an entry (first busy cycle without a read) needs IE, a boundary and a request
  a_r2_take_gated: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(busy) && !mem_re) |-> ($past(psr_q[IE_BIT]) && $past(instr_end) && $past(|irq_req)));

  // R7: a return (first busy cycle reads) needs the command at a boundary
  a_r7_ret_start: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(busy) && mem_re) |-> ($past(iret_req) && $past(instr_end)));

  // R3: single port, never read and write together
  a_r3_port_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we && mem_re));

  // R4: SP only moves by one
  a_r4_sp_step: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sp_q) |-> ((sp_q == $past(sp_q) - 1'b1) || (sp_q == $past(sp_q) + 1'b1)));

  // R5: interrupts are off when acknowledged
  a_r5_ack_ie_off: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack |-> !psr_q[IE_BIT]);

  // R6: one-cycle acknowledge followed by the PC load
  a_r6_ack_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack |=> (pc_we && !irq_ack));

  // R9: no strobe outside a sequence
  a_r9_strobe_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we || mem_re || irq_ack || pc_we) |-> busy);
endmodule

bind irq_seq irq_seq_chk #(
  .NUM_IRQ(NUM_IRQ), .AW(AW), .DW(DW), .IE_BIT(IE_BIT)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .irq_req   (irq_req),
  .instr_end (instr_end),
  .iret_req  (iret_req),
  .psr_q     (psr_q),
  .sp_q      (sp_q),
  .busy      (busy),
  .irq_ack   (irq_ack),
  .pc_we     (pc_we),
  .mem_we    (mem_we),
  .mem_re    (mem_re)
);

// File: tb/test_irq_seq.sv
module test_irq_seq;
  localparam int NI = 4;
  localparam int AW = 8;
  localparam int DW = 16;
  localparam logic [AW-1:0] TOP = 8'hF0;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [NI-1:0] irq_req;
  logic          instr_end, iret_req, psr_we;
  logic [DW-1:0] pc_cur, vec_addr, psr_wdata;
  logic [DW-1:0] psr_q, pc_wdata, mem_wdata, mem_rdata;
  logic [AW-1:0] sp_q, mem_addr;
  logic          busy, irq_ack, pc_we, mem_we, mem_re;

  logic [DW-1:0] mem [0:255];
  assign mem_rdata = mem[mem_addr];

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  irq_seq #(.NUM_IRQ(NI), .AW(AW), .DW(DW), .IE_BIT(0), .STACK_TOP(240)) i_irq_seq (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .instr_end(instr_end),
    .iret_req(iret_req), .pc_cur(pc_cur), .vec_addr(vec_addr), .psr_we(psr_we),
    .psr_wdata(psr_wdata), .psr_q(psr_q), .sp_q(sp_q), .busy(busy),
    .irq_ack(irq_ack), .pc_we(pc_we), .pc_wdata(pc_wdata), .mem_we(mem_we),
    .mem_re(mem_re), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  always @(posedge clk) if (mem_we) mem[mem_addr] <= mem_wdata;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference: phase number plus a stack queue
  int            ph;
  logic [AW-1:0] m_sp;
  logic [DW-1:0] m_sr, m_pc, m_vec;
  logic [DW-1:0] stk [$];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph = 0; m_sp = TOP; m_sr = '0; stk.delete();
    end else begin
      case (ph)
        0: begin
          if (instr_end && iret_req) ph = 11;
          else if (instr_end && (|irq_req) && m_sr[0]) begin ph = 1; m_pc = pc_cur; end
          if (psr_we) m_sr = psr_wdata;
        end
        1:  begin m_sp = m_sp - 1'b1; ph = 2; end
        2:  begin stk.push_back(m_pc); ph = 3; end
        3:  begin m_sp = m_sp - 1'b1; ph = 4; end
        4:  begin stk.push_back(m_sr); ph = 5; end
        5:  begin m_sr[0] = 1'b0; ph = 6; end
        6:  begin m_vec = vec_addr; ph = 7; end
        7:  ph = 0;
        11: begin m_sr = stk.pop_back(); ph = 12; end
        12: begin m_sp = m_sp + 1'b1; ph = 13; end
        13: begin void'(stk.pop_back()); ph = 14; end
        14: begin m_sp = m_sp + 1'b1; ph = 0; end
        default: ph = 0;
      endcase
    end
  end

  // cycle-by-cycle comparison
  always @(negedge clk) begin
    if (rst_n && !done) begin
      logic e_we, e_re, e_pcwe;
      e_we   = (ph == 2) || (ph == 4);
      e_re   = (ph == 11) || (ph == 13);
      e_pcwe = (ph == 7) || (ph == 13);
      check(ph >= 11 ? "R7 busy" : "R3 busy", 32'(busy), 32'(ph != 0));
      check("R3 mem_we", 32'(mem_we), 32'(e_we));
      check("R7 mem_re", 32'(mem_re), 32'(e_re));
      check("R6 irq_ack", 32'(irq_ack), 32'(ph == 6));
      check("R6 pc_we", 32'(pc_we), 32'(e_pcwe));
      check("R4 sp", 32'(sp_q), 32'(m_sp));
      check("R5 psr", 32'(psr_q), 32'(m_sr));
      if (e_we || e_re) check("R4 mem_addr", 32'(mem_addr), 32'(m_sp));
      if (e_we) check("R3 mem_wdata", 32'(mem_wdata), 32'(ph == 2 ? m_pc : m_sr));
      if (e_pcwe) check(ph == 7 ? "R6 pc_wdata" : "R7 pc_wdata", 32'(pc_wdata),
                        32'(ph == 7 ? m_vec : stk[$]));
    end
  end

  task automatic step();
    @(negedge clk);
  endtask

  task automatic boundary();
    instr_end = 1'b1; step(); instr_end = 1'b0;
  endtask

  task automatic run_idle(output int acks, output logic [DW-1:0] last_pc);
    int n = 0;
    acks = 0; last_pc = '0;
    while (busy && n < 50) begin
      if (irq_ack) acks++;
      if (pc_we) last_pc = pc_wdata;
      step(); n++;
    end
  endtask

  task automatic set_sr(logic [DW-1:0] v);
    psr_we = 1'b1; psr_wdata = v; step(); psr_we = 1'b0;
  endtask

  task automatic do_return(output logic [DW-1:0] pc_back);
    int a;
    iret_req = 1'b1; boundary(); iret_req = 1'b0;
    run_idle(a, pc_back);
  endtask

  initial begin
    #(20ns * 100000);
    fails++;
    $display("FAIL watchdog expired at %0t", $time);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int a;
    logic [DW-1:0] lp;
    rst_n = 1'b0; irq_req = '0; instr_end = 0; iret_req = 0; psr_we = 0;
    pc_cur = '0; vec_addr = '0; psr_wdata = '0;
    repeat (3) step();
    // R10: reset state
    check("R10 sp", 32'(sp_q), 32'(TOP));
    check("R10 psr", 32'(psr_q), 32'h0);
    check("R10 busy", 32'(busy), 32'h0);
    check("R10 strobes", 32'({mem_we, mem_re, irq_ack, pc_we}), 32'h0);
    rst_n = 1'b1;
    repeat (4) step();

    // R2: masked request is not served, then taken once IE is set
    irq_req = 4'b0010; pc_cur = 16'h0400; vec_addr = 16'h0800;
    boundary();
    check("R2 masked", 32'(busy), 32'h0);
    repeat (2) step();
    check("R2 still pending", 32'(busy), 32'h0);
    set_sr(16'h1231);
    repeat (3) step();
    check("R2 no boundary", 32'(busy), 32'h0);
    boundary();
    check("R2 taken", 32'(busy), 32'h1);
    run_idle(a, lp);
    irq_req = '0;
    check("R6 one ack", 32'(a), 32'd1);
    check("R6 vector", 32'(lp), 32'h0800);
    check("R4 sp after entry", 32'(sp_q), 32'(TOP - 8'd2));
    check("R3 pushed pc", 32'(mem[TOP - 8'd1]), 32'h0400);
    check("R5 pushed psr", 32'(mem[TOP - 8'd2]), 32'h1231);
    check("R5 ie cleared", 32'(psr_q), 32'h1230);
    do_return(lp);
    check("R7 pc restored", 32'(lp), 32'h0400);
    check("R7 ie back on", 32'(psr_q), 32'h1231);
    check("R4 sp after return", 32'(sp_q), 32'(TOP));

    // R1: each line on its own starts an entry
    for (int i = 0; i < NI; i++) begin
      irq_req = NI'(1) << i; pc_cur = 16'h0100 + 16'(i); vec_addr = 16'h0900 + 16'(i);
      boundary();
      run_idle(a, lp);
      irq_req = '0;
      check("R1 line vector", 32'(lp), 32'(16'h0900 + 16'(i)));
      do_return(lp);
      check("R1 line return", 32'(lp), 32'(16'h0100 + 16'(i)));
    end

    // R9: inputs ignored while busy
    irq_req = 4'b0100; pc_cur = 16'h0222; vec_addr = 16'h0A00;
    boundary();
    while (busy) begin
      psr_we = 1'b1; psr_wdata = 16'hFFFF; instr_end = 1'b1; iret_req = 1'b1;
      step();
    end
    psr_we = 0; instr_end = 0; iret_req = 0; irq_req = '0;
    step();
    check("R9 psr untouched", 32'(psr_q), 32'h1230);
    check("R9 no return", 32'(sp_q), 32'(TOP - 8'd2));

    // R11: nested entry
    set_sr(16'h00C1);
    irq_req = 4'b1000; pc_cur = 16'h0333; vec_addr = 16'h0B00;
    boundary();
    run_idle(a, lp);
    irq_req = '0;
    check("R11 nested sp", 32'(sp_q), 32'(TOP - 8'd4));
    do_return(lp);
    check("R11 inner pc", 32'(lp), 32'h0333);
    check("R11 inner psr", 32'(psr_q), 32'h00C1);

    // R8: return wins over a takeable interrupt at the same boundary
    irq_req = 4'b0001; iret_req = 1'b1; instr_end = 1'b1;
    step(); instr_end = 1'b0; iret_req = 1'b0;
    check("R8 return first", 32'(mem_re), 32'h1);
    run_idle(a, lp);
    check("R11 outer pc", 32'(lp), 32'h0222);
    check("R11 outer sp", 32'(sp_q), 32'(TOP));
    // restored IE=1 and request still held: next boundary enters
    pc_cur = 16'h0444; vec_addr = 16'h0C00;
    boundary();
    check("R8 irq after return", 32'(busy), 32'h1);
    run_idle(a, lp);
    irq_req = '0;
    check("R6 vector again", 32'(lp), 32'h0C00);
    do_return(lp);
    check("R7 final pc", 32'(lp), 32'h0444);
    check("R7 final psr", 32'(psr_q), 32'h1231);

    repeat (3) step();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule